// File: doc/BRIEF.md
# Cache Tag Store with Equality Match

This block keeps one tag per cache line and answers, for a presented line index and tag, whether the stored tag equals the presented one. A wide address is split in two. The low bits pick a word in the store. The high bits are the tag that is written into that word or compared against it. With the default sizes, 13 index bits and an 8-bit tag cover a 21-bit address space.

The same port set does four things. It writes a tag, reads a tag back, compares a tag, or does nothing while deselected. A separate clear input empties the whole store at one clock edge, so every tag reads as zero afterwards.

The compare result leaves the block as a drive-low request plus the resolved local level, which is the inverse of that request. Several instances can share one match line by ANDing their levels. The line then reads high only when every instance sees equality. Two instances given the same index but different tag slices compare a tag twice as wide.

Top module: `tag_match_store`

## Requirements
- R1: After a clock edge with `rst` or `clear_i` high, every word reads as all zeros, whatever it held before.
- R2: While `clear_i` is high, `match_pull_low_o` is 0, `match_o` is 1 and `dout_en_o` is 0. A write presented during clear does not change any word.
- R3: With `sel_i` low and `clear_i` low, `dout_en_o` is 0, `dout_o` is all zeros and `match_o` is 1. `wr_i` has no effect on the stored words.
- R4: With `sel_i` and `wr_i` high, the rising edge stores `din_i` at `addr_i`. During the write `dout_en_o` is 0 and `match_o` is 1, whatever `oe_i` is.
- R5: With `sel_i` and `oe_i` high and `wr_i` low, `dout_o` shows the word at `addr_i` in the same cycle, `dout_en_o` is 1 and `match_o` is 1.
- R6: With `sel_i` high and both `wr_i` and `oe_i` low, `match_pull_low_o` is 1 exactly when the word at `addr_i` differs from `din_i`. `dout_en_o` is 0.
- R7: A compare or read in the cycle right after a write to the same address sees the newly written tag.
- R8: `match_o` is always the inverse of `match_pull_low_o`. The AND of `match_o` over instances that share index and controls is 1 only when every instance's tag slice matches.
- R9: A word not written since the last clear compares equal to 8'h00 and unequal to any nonzero tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset; empties the store like clear |
| clear_i | input | 1 | Bulk clear: zeroes every word at the next edge |
| sel_i | input | 1 | Chip select, active high |
| wr_i | input | 1 | Write enable, active high |
| oe_i | input | 1 | Output enable for reads, active high |
| addr_i | input | ADDR_W | Word index (low address bits) |
| din_i | input | TAG_W | Tag to write or to compare |
| dout_o | output | TAG_W | Read data, zero when not driving |
| dout_en_o | output | 1 | High when `dout_o` carries read data |
| match_pull_low_o | output | 1 | Request to pull the shared match line low |
| match_o | output | 1 | Local resolved match level |

## Verification
The bench builds two instances with `ADDR_W` = 6 and `TAG_W` = 8, so each store holds 64 words. At that depth it can sweep every word after a bulk clear and confirm that nothing survives, which the default depth would make slow. The two instances share index and controls but hold different tag slices, which makes a 16-bit cascaded compare. Mismatches in either half, or in both, can then be seen on the combined line.

// File: rtl/tagm_pkg.sv
package tagm_pkg;

  typedef enum logic [2:0] {
    MODE_IDLE  = 3'd0,
    MODE_CLEAR = 3'd1,
    MODE_WRITE = 3'd2,
    MODE_READ  = 3'd3,
    MODE_CMP   = 3'd4
  } tagm_mode_e;

  // Priority: clear beats deselect, deselect beats write, write beats read.
  function automatic tagm_mode_e decode_mode(input logic clr, input logic sel,
                                             input logic wr, input logic oe);
    if (clr)       return MODE_CLEAR;
    else if (!sel) return MODE_IDLE;
    else if (wr)   return MODE_WRITE;
    else if (oe)   return MODE_READ;
    else           return MODE_CMP;
  endfunction

endpackage

// File: rtl/tagm_ctrl.sv
module tagm_ctrl
  import tagm_pkg::*;
(
  input  logic clr_any,
  input  logic sel,
  input  logic wr,
  input  logic oe,
  output logic wr_en,
  output logic rd_drive,
  output logic cmp_en,
  output logic wipe
);

  tagm_mode_e mode;

  always_comb begin
    mode     = decode_mode(clr_any, sel, wr, oe);
    wr_en    = (mode == MODE_WRITE);
    rd_drive = (mode == MODE_READ);
    cmp_en   = (mode == MODE_CMP);
    wipe     = (mode == MODE_CLEAR);
  end

endmodule

// File: rtl/tagm_store.sv
module tagm_store #(
  parameter int ADDR_W = 13,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              wipe,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [TAG_W-1:0]  wdata,
  output logic [TAG_W-1:0]  rdata
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [TAG_W-1:0] words [DEPTH];
  logic [DEPTH-1:0] live;

  // Tag words carry no reset so the array stays a plain memory.
  always_ff @(posedge clk) begin
    if (wr_en) words[addr] <= wdata;
  end

  // One live bit per word; clearing them all empties the store in one edge.
  always_ff @(posedge clk) begin
    if (wipe)       live       <= '0;
    else if (wr_en) live[addr] <= 1'b1;
  end

  assign rdata = live[addr] ? words[addr] : '0;

endmodule

// File: rtl/tagm_cmp.sv
module tagm_cmp #(
  parameter int TAG_W = 8
) (
  input  logic             cmp_en,
  input  logic [TAG_W-1:0] stored,
  input  logic [TAG_W-1:0] probe,
  output logic             pull_low
);

  logic [TAG_W-1:0] diff;

  for (genvar b = 0; b < TAG_W; b++) begin : g_bit
    assign diff[b] = stored[b] ^ probe[b];
  end

  assign pull_low = cmp_en & (|diff);

endmodule

// File: rtl/tag_match_store.sv
module tag_match_store #(
  parameter int ADDR_W = 13,
  parameter int TAG_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear_i,
  input  logic              sel_i,
  input  logic              wr_i,
  input  logic              oe_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [TAG_W-1:0]  din_i,
  output logic [TAG_W-1:0]  dout_o,
  output logic              dout_en_o,
  output logic              match_pull_low_o,
  output logic              match_o
);

  logic             wr_en;
  logic             rd_drive;
  logic             cmp_en;
  logic             wipe;
  logic [TAG_W-1:0] rdata;
  logic             pull_low;

  tagm_ctrl u_ctrl (
    .clr_any  (rst | clear_i),
    .sel      (sel_i),
    .wr       (wr_i),
    .oe       (oe_i),
    .wr_en    (wr_en),
    .rd_drive (rd_drive),
    .cmp_en   (cmp_en),
    .wipe     (wipe)
  );

  tagm_store #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_store (
    .clk   (clk),
    .wipe  (wipe),
    .wr_en (wr_en),
    .addr  (addr_i),
    .wdata (din_i),
    .rdata (rdata)
  );

  tagm_cmp #(.TAG_W(TAG_W)) u_cmp (
    .cmp_en   (cmp_en),
    .stored   (rdata),
    .probe    (din_i),
    .pull_low (pull_low)
  );

  assign dout_o           = rd_drive ? rdata : '0;
  assign dout_en_o        = rd_drive;
  assign match_pull_low_o = pull_low;
  assign match_o          = ~pull_low;

endmodule

// File: rtl/tagm_checker.sv
module tagm_checker #(
  parameter int ADDR_W = 13,
  parameter int TAG_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              clear_i,
  input logic              sel_i,
  input logic              wr_i,
  input logic              oe_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [TAG_W-1:0]  din_i,
  input logic [TAG_W-1:0]  dout_o,
  input logic              dout_en_o,
  input logic              match_pull_low_o,
  input logic              match_o
);

  logic rd_req;
  logic wr_req;
  assign rd_req = sel_i && !wr_i && oe_i && !clear_i;
  assign wr_req = sel_i && wr_i && !clear_i;

  assert_clear_idle_R2: assert property (@(posedge clk) disable iff (rst)
    clear_i |-> (!match_pull_low_o && match_o && !dout_en_o));

  assert_deselect_R3: assert property (@(posedge clk) disable iff (rst)
    (!sel_i && !clear_i) |-> (!dout_en_o && dout_o == '0 && match_o));

  assert_write_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    wr_req |-> (!dout_en_o && match_o));

  assert_read_drive_R5: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (dout_en_o && match_o));

  assert_clear_empties_R1: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (!rd_req || dout_o == '0));

  assert_write_visible_R7: assert property (@(posedge clk) disable iff (rst)
    wr_req |=> (!(rd_req && addr_i == $past(addr_i)) || dout_o == $past(din_i)));

  assert_level_R8: assert property (@(posedge clk) disable iff (rst)
    match_o == !match_pull_low_o);

endmodule

bind tag_match_store tagm_checker #(.ADDR_W(ADDR_W), .TAG_W(TAG_W)) u_chk (
  .clk              (clk),
  .rst              (rst),
  .clear_i          (clear_i),
  .sel_i            (sel_i),
  .wr_i             (wr_i),
  .oe_i             (oe_i),
  .addr_i           (addr_i),
  .din_i            (din_i),
  .dout_o           (dout_o),
  .dout_en_o        (dout_en_o),
  .match_pull_low_o (match_pull_low_o),
  .match_o          (match_o)
);

// File: tb/sim_tag_match_store.sv
`timescale 1ns/1ps
module sim_tag_match_store;

  localparam int AW    = 6;
  localparam int TW    = 8;
  localparam int WORDS = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          clear_i = 1'b0;
  logic          sel_i = 1'b0;
  logic          wr_i = 1'b0;
  logic          oe_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [TW-1:0] din0 = '0;
  logic [TW-1:0] din1 = '0;
  logic [TW-1:0] dout0, dout1;
  logic          den0, den1, pl0, pl1, m0, m1;
  logic          line;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [TW-1:0] model0 [int];
  logic [TW-1:0] model1 [int];

  always #2 clk = ~clk;

  tag_match_store #(.ADDR_W(AW), .TAG_W(TW)) u0 (
    .clk(clk), .rst(rst), .clear_i(clear_i), .sel_i(sel_i), .wr_i(wr_i),
    .oe_i(oe_i), .addr_i(addr_i), .din_i(din0), .dout_o(dout0),
    .dout_en_o(den0), .match_pull_low_o(pl0), .match_o(m0));

  tag_match_store #(.ADDR_W(AW), .TAG_W(TW)) u1 (
    .clk(clk), .rst(rst), .clear_i(clear_i), .sel_i(sel_i), .wr_i(wr_i),
    .oe_i(oe_i), .addr_i(addr_i), .din_i(din1), .dout_o(dout1),
    .dout_en_o(den1), .match_pull_low_o(pl1), .match_o(m1));

  assign line = m0 & m1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] look(ref logic [TW-1:0] m [int], input int a);
    return m.exists(a) ? m[a] : '0;
  endfunction

  task automatic do_write(input logic [AW-1:0] a, input logic [TW-1:0] d0,
                          input logic [TW-1:0] d1, input logic oe);
    @(negedge clk);
    sel_i = 1; wr_i = 1; oe_i = oe; addr_i = a; din0 = d0; din1 = d1;
    #1;
    check("R4 dout_en during write", den0, 0);
    check("R4 match during write", line, 1);
    @(posedge clk);
    model0[a] = d0; model1[a] = d1;
  endtask

  task automatic do_read(input logic [AW-1:0] a, input string req);
    @(negedge clk);
    sel_i = 1; wr_i = 0; oe_i = 1; addr_i = a;
    #1;
    check({req, " dout0"}, dout0, look(model0, a));
    check({req, " dout1"}, dout1, look(model1, a));
    check({req, " dout_en"}, den0 & den1, 1);
    check({req, " match"}, line, 1);
  endtask

  task automatic do_cmp(input logic [AW-1:0] a, input logic [TW-1:0] d0,
                        input logic [TW-1:0] d1, input string req);
    logic e0, e1;
    @(negedge clk);
    sel_i = 1; wr_i = 0; oe_i = 0; addr_i = a; din0 = d0; din1 = d1;
    e0 = (look(model0, a) == d0);
    e1 = (look(model1, a) == d1);
    #1;
    check({req, " pull0"}, pl0, !e0);
    check({req, " pull1"}, pl1, !e1);
    check({req, " R8 shared line"}, line, e0 & e1);
    check({req, " R8 level"}, m0, !pl0);
    check({req, " dout_en"}, den0, 0);
  endtask

  task automatic t_reset;
    @(negedge clk);
    #1;
    check("R3 idle dout_en after reset", den0, 0);
    check("R3 idle match after reset", line, 1);
    do_read(0, "R1 reset read");
    do_read(WORDS - 1, "R1 reset read top");
    do_cmp(5, 8'h00, 8'h00, "R9 reset compare zero");
  endtask

  task automatic t_write_read;
    do_write(3, 8'hA5, 8'h5A, 1'b1);
    do_write(17, 8'hFF, 8'h01, 1'b0);
    do_write(WORDS - 1, 8'h80, 8'h7F, 1'b1);
    do_read(3, "R5 read");
    do_read(17, "R5 read");
    do_read(WORDS - 1, "R5 read top");
    do_write(3, 8'h3C, 8'hC3, 1'b0);
    do_read(3, "R4 overwrite");
  endtask

  task automatic t_compare;
    do_cmp(17, 8'hFF, 8'h01, "R6 both equal");
    do_cmp(17, 8'hFE, 8'h01, "R6 low half differs");
    do_cmp(17, 8'hFF, 8'h03, "R6 high half differs");
    do_cmp(17, 8'h00, 8'h00, "R6 both differ");
    do_cmp(40, 8'h01, 8'h00, "R9 unwritten vs nonzero");
  endtask

  task automatic t_back_to_back;
    do_write(9, 8'h11, 8'h22, 1'b0);
    do_cmp(9, 8'h11, 8'h22, "R7 compare after write");
    do_write(9, 8'h33, 8'h44, 1'b0);
    do_read(9, "R7 read after write");
    do_write(9, 8'h55, 8'h66, 1'b0);
    do_cmp(9, 8'h33, 8'h44, "R7 stale tag mismatches");
  endtask

  task automatic t_deselect;
    @(negedge clk);
    sel_i = 0; wr_i = 1; oe_i = 1; addr_i = 3; din0 = 8'h99; din1 = 8'h99;
    #1;
    check("R3 deselect dout_en", den0 | den1, 0);
    check("R3 deselect dout", dout0, 0);
    check("R3 deselect match", line, 1);
    @(posedge clk);
    do_read(3, "R3 write ignored while deselected");
  endtask

  task automatic t_clear;
    @(negedge clk);
    clear_i = 1; sel_i = 1; wr_i = 0; oe_i = 0; addr_i = 17; din0 = 8'h00; din1 = 8'h00;
    #1;
    check("R2 compare released in clear", pl0 | pl1, 0);
    check("R2 line high in clear", line, 1);
    @(negedge clk);
    wr_i = 1; oe_i = 1; addr_i = 20; din0 = 8'hAB; din1 = 8'hCD;
    #1;
    check("R2 dout_en in clear", den0, 0);
    @(posedge clk);
    model0.delete(); model1.delete();
    @(negedge clk);
    clear_i = 0; wr_i = 0;
    do_read(20, "R2 write ignored in clear");
    for (int a = 0; a < WORDS; a++) do_read(a[AW-1:0], "R1 sweep after clear");
    do_cmp(17, 8'h00, 8'h00, "R9 cleared compare zero");
    do_cmp(3, 8'h3C, 8'h00, "R9 cleared compare old tag");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    t_reset;
    t_write_read;
    t_compare;
    t_back_to_back;
    t_deselect;
    t_clear;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(100000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual timeout expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule